// File: doc/BRIEF.md
# MDIO Management Access Controller

This block is a register-driven management master for the two-wire PHY management bus (MDC clock, bidirectional MDIO data). Software sets an enable bit and an 8-bit clock divider in a control register. It then writes one command word to an access register with the go bit set. The block sends a complete clause-22 read or write frame and clears the go/busy bit when the frame is over. After a read, the same register holds the 16 bits the PHY returned.

The MDIO line is split into an output, an output enable and an input, so the pad-level tri-state sits outside the block. During a read, the controller watches the second turnaround bit. If a PHY pulls it low, the controller sets that PHY address's bit in a sticky 32-bit presence register. This shows software which addresses have a device behind them.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After a synchronous active-low reset:
  - the control register reads 0x8000_0000 (idle bit set, disabled, divider 0);
  - the access register and the presence register read 0;
  - `mdc` and `mdio_oe` are low.
- R2: Register select `reg_addr` 0 is the control register:
  - bit 30 is enable (read/write);
  - bit 31 reads 1 exactly when no frame is in progress;
  - bits 7:0 are the divider.
  Select 1 is the access register. Select 2 is the read-only presence register. Select 3 reads 0.
- R3: Starting a frame:
  - A write to the access register with bit 31 set, while enabled and not busy, starts a frame.
  - Bit 31 then reads 1 from the next cycle until the frame ends, and then reads 0.
  - The same write while disabled stores the fields but starts nothing.
- R4: Access register layout:
  - bit 30 selects write;
  - bits 25:21 are the register number;
  - bits 20:16 are the PHY address;
  - bits 15:0 are the data.
  Each frame sends, in order and MSB first:
  - 32 ones;
  - start 01;
  - opcode (10 for read, 01 for write);
  - PHY address;
  - register number;
  - turnaround (10 on writes);
  - 16 data bits.
- R5: MDC rules:
  - `mdc` is low whenever no frame is in progress.
  - With divider value D, each MDC high phase lasts D+1 system clocks.
  - `mdio_o` changes only while `mdc` is low (on falling edges). Input is sampled on rising edges.
- R6: During a read, `mdio_oe` is high for the first 46 bits and low for the two turnaround bits and the 16 data bits. When the frame ends, the access register's bits 15:0 hold the bits sampled in the data phase.
- R7: Presence tracking:
  - Presence bit N is set when a read to PHY address N samples the second turnaround bit as 0.
  - A read whose turnaround stays high leaves the bit unchanged.
  - Bits clear only on reset.
- R8: A write to the access register while busy is ignored. The running frame and the register contents are unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 control, 1 access, 2 presence) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
Some rules are checked on every clock by the assertions:
- MDC and the output enable stay low while idle;
- `mdio_o` never moves while MDC is high;
- a frame only starts when enabled;
- the command fields stay frozen while busy;
- presence bits never clear.

Other behaviour can only be shown by the bench's scenarios, using a PHY model that decodes each captured frame:
- the exact bit sequence on the wire;
- the MDC high width for each divider;
- the returned read data;
- a pull-up (all ones) read from an absent address;
- the discarded mid-frame write.

// File: rtl/mdio_pkg.sv
// Shared constants and types of the MDIO management controller.
// Assumes clause-22 framing: fixed field widths and a 64-bit frame.
package mdio_pkg;
    localparam int PRE_BITS   = 32;
    localparam int PHY_AW     = 5;
    localparam int REG_AW     = 5;
    localparam int DATA_W     = 16;
    localparam int FRAME_BITS = PRE_BITS + 2 + 2 + PHY_AW + REG_AW + 2 + DATA_W;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int TA_FIRST   = PRE_BITS + 4 + PHY_AW + REG_AW;
    localparam int TA_SECOND  = TA_FIRST + 1;
    localparam int DATA_FIRST = TA_FIRST + 2;
    localparam int ALIVE_N    = 1 << PHY_AW;

    localparam logic [1:0] SEL_CTRL   = 2'd0;
    localparam logic [1:0] SEL_ACCESS = 2'd1;
    localparam logic [1:0] SEL_ALIVE  = 2'd2;

    localparam int CTRL_IDLE_BIT = 31;
    localparam int CTRL_EN_BIT   = 30;

    typedef struct packed {
        logic              busy;
        logic              wr;
        logic [3:0]        rsvd;
        logic [REG_AW-1:0] regad;
        logic [PHY_AW-1:0] phyad;
        logic [DATA_W-1:0] data;
    } access_t;
endpackage

// File: rtl/mdio_clk_gen.sv
// MDC generator: toggles MDC every DIV+1 system clocks while run is high.
// Strobes mark the clock edge at which MDC rises or falls. MDC is held low
// while run is low. The divider is captured on load so a frame keeps one rate.
module mdio_clk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             load,
    input  logic [DIV_W-1:0] div_in,
    output logic             mdc,
    output logic             rise_stb,
    output logic             fall_stb
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] div_q;
    logic             tick;

    assign tick     = run && (cnt == div_q);
    assign rise_stb = tick && !mdc;
    assign fall_stb = tick && mdc;

    // Capture the divider for the frame about to start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_q <= '0;
        else if (load)
            div_q <= div_in;
    end

    // Count half periods and toggle MDC; park low when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (!run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (tick) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_frame_engine.sv
// Frame engine: shifts one 64-bit clause-22 frame out on MDC falling edges.
// During reads it samples the turnaround acknowledge and the data on rising
// edges. It assumes that the first rising strobe follows start by at least
// one cycle. done is combinational, on the final falling edge.
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wr,
    input  logic [PHY_AW-1:0] phy,
    input  logic [REG_AW-1:0] regad,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rise_stb,
    input  logic              fall_stb,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              done,
    output logic              is_rd,
    output logic              ack,
    output logic [DATA_W-1:0] rdata
);
    logic [FRAME_BITS-1:0] sr;
    logic [IDX_W-1:0]      idx;
    logic                  active;
    logic                  oe_q;
    logic                  last_bit;

    // Assemble the outgoing frame from the command fields.
    function automatic logic [FRAME_BITS-1:0] build(input logic w,
            input logic [PHY_AW-1:0] p, input logic [REG_AW-1:0] r,
            input logic [DATA_W-1:0] d);
        logic [1:0] op;
        logic [1:0] ta;
        op = w ? 2'b01 : 2'b10;
        ta = w ? 2'b10 : 2'b11;
        return {{PRE_BITS{1'b1}}, 2'b01, op, p, r, ta, d};
    endfunction

    assign last_bit = (idx == IDX_W'(FRAME_BITS - 1));
    assign done     = active && fall_stb && last_bit;
    assign mdio_o   = sr[FRAME_BITS-1];
    assign mdio_oe  = oe_q;

    // Load the frame on start and advance one bit per falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr     <= '1;
            idx    <= '0;
            active <= 1'b0;
            is_rd  <= 1'b0;
            oe_q   <= 1'b0;
        end else if (start) begin
            sr     <= build(wr, phy, regad, wdata);
            idx    <= '0;
            active <= 1'b1;
            is_rd  <= !wr;
            oe_q   <= 1'b1;
        end else if (active && fall_stb) begin
            if (last_bit) begin
                active <= 1'b0;
                oe_q   <= 1'b0;
            end else begin
                idx  <= idx + 1'b1;
                sr   <= {sr[FRAME_BITS-2:0], 1'b1};
                oe_q <= !is_rd || ((int'(idx) + 1) < TA_FIRST);
            end
        end
    end

    // Sample the acknowledge and the read data on rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack   <= 1'b0;
            rdata <= '0;
        end else if (start) begin
            ack <= 1'b0;
        end else if (active && rise_stb && is_rd) begin
            if (idx == IDX_W'(TA_SECOND))
                ack <= !mdio_i;
            if (int'(idx) >= DATA_FIRST)
                rdata <= {rdata[DATA_W-2:0], mdio_i};
        end
    end
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
// MDIO management controller top: control, access and presence registers
// around the MDC generator and the frame engine. Assumes a single register
// master; read data is combinational from the register select.
module mdio_mgmt_ctrl
    import mdio_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic               ctrl_en;
    logic [DIV_W-1:0]   ctrl_div;
    access_t            acc;
    access_t            wr_acc;
    logic [ALIVE_N-1:0] alive;
    logic [ALIVE_N-1:0] alive_set;
    logic               acc_sel;
    logic               start;
    logic               rise_stb;
    logic               fall_stb;
    logic               eng_done;
    logic               eng_rd;
    logic               eng_ack;
    logic [DATA_W-1:0]  eng_rdata;

    assign wr_acc  = access_t'(reg_wdata);
    assign acc_sel = reg_wr && (reg_addr == SEL_ACCESS);
    assign start   = acc_sel && !acc.busy && wr_acc.busy && ctrl_en;

    // Control register: enable and divider.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en  <= 1'b0;
            ctrl_div <= '0;
        end else if (reg_wr && (reg_addr == SEL_CTRL)) begin
            ctrl_en  <= reg_wdata[CTRL_EN_BIT];
            ctrl_div <= reg_wdata[DIV_W-1:0];
        end
    end

    // Access register: accept a command only while idle; close it on done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (eng_done) begin
            acc.busy <= 1'b0;
            if (eng_rd)
                acc.data <= eng_rdata;
        end else if (acc_sel && !acc.busy) begin
            acc      <= wr_acc;
            acc.busy <= start;
        end
    end

    // One set term per PHY address for the presence register.
    for (genvar i = 0; i < ALIVE_N; i++) begin : g_alive
        assign alive_set[i] = eng_done && eng_rd && eng_ack &&
                              (acc.phyad == PHY_AW'(i));
    end

    // Presence register: sticky until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            alive <= '0;
        else
            alive <= alive | alive_set;
    end

    // Register read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            SEL_CTRL: begin
                reg_rdata[CTRL_IDLE_BIT] = !acc.busy;
                reg_rdata[CTRL_EN_BIT]   = ctrl_en;
                reg_rdata[DIV_W-1:0]     = ctrl_div;
            end
            SEL_ACCESS: reg_rdata = acc;
            SEL_ALIVE:  reg_rdata = 32'(alive);
            default:    reg_rdata = '0;
        endcase
    end

    mdio_clk_gen #(.DIV_W(DIV_W)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (acc.busy),
        .load     (start),
        .div_in   (ctrl_div),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_frame_engine u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .wr       (wr_acc.wr),
        .phy      (wr_acc.phyad),
        .regad    (wr_acc.regad),
        .wdata    (wr_acc.data),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .mdio_i   (mdio_i),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .done     (eng_done),
        .is_rd    (eng_rd),
        .ack      (eng_ack),
        .rdata    (eng_rdata)
    );
endmodule

// File: rtl/mdio_mgmt_ctrl_chk.sv
// Protocol checker for the MDIO management controller, bound to the top.
// Assumes the synchronous active-low reset of the design.
module mdio_mgmt_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        ctrl_en,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic [31:0] acc,
    input logic [31:0] alive
);
    // MDC parked low outside a frame (R5).
    p_mdc_idle_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    // Bus released outside a frame (R6).
    p_oe_idle_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);

    // Output only moves while MDC is low (R5).
    p_mdio_hold_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> $stable(mdio_o));

    // A frame only begins while enabled (R3).
    p_start_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ctrl_en);

    // A frame begins by driving the bus (R4).
    p_start_drives_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> mdio_oe);

    // Command fields frozen during a frame (R8).
    p_fields_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(acc[30:0]));

    // Presence bits never clear (R7).
    p_alive_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((alive & $past(alive)) == $past(alive)));
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (acc.busy),
    .ctrl_en (ctrl_en),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .acc     (acc),
    .alive   (alive)
);

// File: tb/mdio_mgmt_ctrl_test.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl_test;
    localparam logic [31:0] PRESENT = 32'h8001_2405;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [1:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;
    logic        phy_drv, phy_bit;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    assign mdio_i = mdio_oe ? mdio_o : (phy_drv ? phy_bit : 1'b1);

    mdio_mgmt_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // PHY model state
    logic [63:0] cap, cap_oe;
    int          rise_cnt;
    longint      t_hi;
    int          hi_w;
    logic        ph_rd;
    logic [4:0]  ph_phy, ph_reg;

    function automatic logic [15:0] phy_val(input logic [4:0] p, input logic [4:0] r);
        return {p, r, r[2:0], p[2:0]} ^ 16'h5A3C;
    endfunction

    always @(posedge mdc) begin
        cap    = {cap[62:0], mdio_i};
        cap_oe = {cap_oe[62:0], mdio_oe};
        rise_cnt++;
        t_hi = $time;
    end

    always @(negedge mdc) begin
        if (rise_cnt > 0) begin
            hi_w = int'(($time - t_hi) / 20);
            if (rise_cnt == 46) begin
                ph_rd  = (cap[11:10] == 2'b10);
                ph_phy = cap[9:5];
                ph_reg = cap[4:0];
            end
            if (ph_rd && PRESENT[ph_phy] && rise_cnt >= 47 && rise_cnt <= 63) begin
                phy_drv = 1'b1;
                phy_bit = (rise_cnt == 47) ? 1'b0 : phy_val(ph_phy, ph_reg)[63 - rise_cnt];
            end else begin
                phy_drv = 1'b0;
            end
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int n = 0; n < 4000; n++) begin
            reg_read(2'd1, v);
            if (!v[31]) return;
        end
    endtask

    logic [31:0] exp_alive = 32'h0;

    // Full transaction with checks; intrude issues a write while busy.
    task automatic xfer(input logic wr, input logic [4:0] p, input logic [4:0] r,
                        input logic [15:0] d, input logic [7:0] dv, input bit intrude);
        logic [31:0] v;
        logic [45:0] hdr;
        logic [15:0] exp_d;
        reg_write(2'd0, {2'b01, 22'h0, dv});
        rise_cnt = 0; cap = '0; cap_oe = '0; ph_rd = 1'b0; phy_drv = 1'b0;
        reg_write(2'd1, {1'b1, wr, 4'h0, r, p, d});
        reg_read(2'd1, v);
        chk("R3 busy after go", 64'(v[31]), 64'd1);
        reg_read(2'd0, v);
        chk("R2 idle bit low in frame", 64'(v[31]), 64'd0);
        if (intrude) begin
            repeat (20) @(negedge clk);
            reg_write(2'd1, 32'hC3FF_FFFF);
        end
        wait_idle();
        repeat (2) @(negedge clk);
        chk("R5 mdc low after frame", 64'(mdc), 64'd0);
        chk("R5 mdc high width", 64'(hi_w), 64'(dv) + 64'd1);
        hdr = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), p, r};
        exp_d = wr ? d : (PRESENT[p] ? phy_val(p, r) : 16'hFFFF);
        if (wr) begin
            chk("R4 write frame bits", cap, {hdr, 2'b10, d});
            chk("R4 write oe mask", cap_oe, 64'hFFFF_FFFF_FFFF_FFFF);
        end else begin
            chk("R4 read header bits", 64'(cap[63:18]), 64'(hdr));
            chk("R6 read oe mask", cap_oe, {46'h3FFF_FFFF_FFFF, 18'h0});
            if (PRESENT[p]) exp_alive[p] = 1'b1;
        end
        reg_read(2'd1, v);
        chk(wr ? "R8 access after write" : "R6 read data", 64'(v),
            64'({1'b0, wr, 4'h0, r, p, exp_d}));
        reg_read(2'd2, v);
        chk("R7 presence", 64'(v), 64'(exp_alive));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd2024));
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
        phy_drv = 1'b0; phy_bit = 1'b1; rise_cnt = 0; hi_w = 0; t_hi = 0;
        ph_rd = 1'b0; ph_phy = '0; ph_reg = '0; cap = '0; cap_oe = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        reg_read(2'd0, v); chk("R1 control reset", 64'(v), 64'h8000_0000);
        reg_read(2'd1, v); chk("R1 access reset", 64'(v), 64'h0);
        reg_read(2'd2, v); chk("R1 presence reset", 64'(v), 64'h0);
        reg_read(2'd3, v); chk("R2 unused select", 64'(v), 64'h0);
        chk("R1 mdc/oe reset", 64'({mdc, mdio_oe}), 64'h0);
        // go while disabled: fields stored, nothing starts
        reg_write(2'd1, 32'hC065_1234);
        repeat (10) @(negedge clk);
        reg_read(2'd1, v); chk("R3 go ignored when disabled", 64'(v), 64'h4065_1234);
        chk("R3 no mdc when disabled", 64'(mdc), 64'h0);
        // control readback
        reg_write(2'd0, 32'h4000_0003);
        reg_read(2'd0, v); chk("R2 control readback", 64'(v), 64'hC000_0003);
        // directed cases
        xfer(1'b1, 5'd3,  5'd4,  16'h1234, 8'd1, 1'b0);
        xfer(1'b0, 5'd0,  5'd2,  16'h0000, 8'd0, 1'b0);
        xfer(1'b0, 5'd1,  5'd9,  16'h0000, 8'd2, 1'b0);
        xfer(1'b0, 5'd31, 5'd31, 16'h0000, 8'd3, 1'b0);
        xfer(1'b1, 5'd3,  5'd4,  16'hBEEF, 8'd1, 1'b1);
        xfer(1'b0, 5'd16, 5'd0,  16'h0000, 8'd0, 1'b1);
        // constrained random
        for (int k = 0; k < 12; k++) begin
            xfer(1'($urandom % 2), 5'($urandom % 32), 5'($urandom % 32),
                 16'($urandom), 8'($urandom % 4), 1'b0);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule